// File: doc/BRIEF.md
# PRBS Sync Monitor

This block watches a stream of wide ADC words that should carry a pseudo-random test pattern. It tells a link bring-up routine whether the pattern is present and aligned, and whether any bit errors occur once it is. Each 56-bit input word holds four 14-bit samples in offset binary. The block converts each sample to two's complement and packs the four samples into one comparison word. It then checks that word against a prediction built from a parallel-stepped shift-register function. A 4-bit select input picks the short (9-stage) or the long (23-stage) pattern.

While the monitor is out of sync it seeds every prediction from the word it just received, so it can lock onto a stream that starts at any point. Once it is in sync it advances its own prediction and no longer follows the incoming data. Lock and loss of lock use different hysteresis: 16 consecutive good words bring the monitor into sync, and a longer run of consecutive bad words (64 by default) takes it out. A per-word error pulse fires only while the monitor is in sync. Words whose valid input is low take no part in any of this.

Top module: `prbs_sync_mon`

## Requirements
- R1: After reset, and while rst_ni is low, oos_o is 1 and err_o is 0.
- R2: Input sample k (data_i bits 14k+13..14k, k = 0..3) has its most significant bit inverted and is placed at comparison-word bits 55-14k..42-14k, so sample 0 occupies the top lane.
- R3: A comparison word is 56 consecutive pattern bits, the oldest bit in bit 55. seq_sel_i = 0 selects b[n] = b[n-9] xor b[n-5]. Any nonzero seq_sel_i selects b[n] = b[n-23] xor b[n-18].
- R4: While oos_o is 1, the prediction for the next valid word is the pattern continued from the word just received.
- R5: oos_o falls after exactly 16 consecutive matching valid words. After 15 it is still 1.
- R6: While in sync, the prediction advances from the previous prediction. One corrupted word therefore gives exactly one error, and the correct words that follow still match.
- R7: While in sync, oos_o rises after UNLOCK_THR (default 64) consecutive mismatching valid words. A single matching word in between restarts that count.
- R8: err_o is a one-cycle pulse for each mismatching valid word judged while in sync. It never fires while out of sync.
- R9: A comparison word of all zeros is always a mismatch. A zero stream never brings the monitor into sync, and a zero word raises an error while in sync.
- R10: Cycles with valid_i low change neither the prediction, the counters, oos_o nor err_o, whatever data_i holds.
- R11: The verdict for a word sampled at clock edge k appears on err_o and oos_o after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Marks data_i as a word to check |
| seq_sel_i | input | 4 | 0: 9-stage pattern, other: 23-stage pattern |
| data_i | input | 56 | Four offset-binary 14-bit samples, sample 0 in the low bits |
| oos_o | output | 1 | 1 while the pattern is not in sync |
| err_o | output | 1 | One-cycle pulse per bad word while in sync |

## Verification
Clean 9-stage and 23-stage streams, sent with the select set to match, show that reseeding and the 16-word lock count work, and that 15 good words are not enough. The same streams sent under the wrong select must never lock, which checks the polynomial choice and the lane packing. Single-bit corruptions at random positions and random garbage runs, with one good word placed in the middle, separate self-running prediction from reseeding and check the restart of the 64-word unlock count. All-zero words and long valid-low stretches filled with random data show that the zero rule holds and that idle cycles are ignored.

// File: rtl/prbs_sync_pkg.sv
package prbs_sync_pkg;
  localparam int unsigned NUM_SEQ = 2;
  // recurrence b[n] = b[n-LEN] ^ b[n-TAP]; index 0 short, 1 long
  localparam int unsigned SEQ_LEN [NUM_SEQ] = '{9, 23};
  localparam int unsigned SEQ_TAP [NUM_SEQ] = '{5, 18};
  typedef enum logic {SEQ_SHORT = 1'b0, SEQ_LONG = 1'b1} seq_e;
endpackage

// File: rtl/prbs_lane_fmt.sv
module prbs_lane_fmt #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 14,
  localparam int unsigned W     = LANES * LANE_W
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] word_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned SRC = k * LANE_W;
    localparam int unsigned DST = (LANES - 1 - k) * LANE_W;
    assign word_o[DST +: LANE_W] = {~raw_i[SRC + LANE_W - 1], raw_i[SRC +: LANE_W-1]};
  end
endmodule

// File: rtl/prbs_predictor.sv
module prbs_predictor
  import prbs_sync_pkg::*;
#(
  parameter int unsigned W     = 56,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             reseed_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     rx_i,
  output logic [W-1:0]     exp_o
);
  // continue the pattern W bits past word w (oldest bit in MSB)
  function automatic logic [W-1:0] pn_step(input logic [W-1:0] w,
                                           input int unsigned len,
                                           input int unsigned tap);
    logic [2*W-1:0] v;
    v = {w, {W{1'b0}}};
    for (int i = 0; i < int'(W); i++) begin
      v[W-1-i] = v[W-1-i+int'(len)] ^ v[W-1-i+int'(tap)];
    end
    return v[W-1:0];
  endfunction

  logic [W-1:0] exp_q;
  logic [W-1:0] seed;
  logic [W-1:0] nxt [NUM_SEQ];
  seq_e         kind;

  assign seed = reseed_i ? rx_i : exp_q;
  assign kind = (sel_i == '0) ? SEQ_SHORT : SEQ_LONG;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    assign nxt[g] = pn_step(seed, SEQ_LEN[g], SEQ_TAP[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    exp_q <= '0;
    else if (adv_i) exp_q <= (kind == SEQ_SHORT) ? nxt[0] : nxt[1];
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/prbs_compare.sv
module prbs_compare #(
  parameter int unsigned W = 56,
  localparam int unsigned HALF = W / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] exp_i,
  output logic         vld_o,
  output logic         match_o
);
  logic hi_q, lo_q, nz_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      nz_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        hi_q <= rx_i[W-1:HALF] == exp_i[W-1:HALF];
        lo_q <= rx_i[HALF-1:0] == exp_i[HALF-1:0];
        nz_q <= |rx_i;
      end
    end
  end

  assign vld_o   = vld_q;
  assign match_o = hi_q & lo_q & nz_q;
endmodule

// File: rtl/prbs_lock.sv
module prbs_lock #(
  parameter int unsigned LOCK_THR   = 16,
  parameter int unsigned UNLOCK_THR = 64,
  localparam int unsigned MAX_THR   = (LOCK_THR > UNLOCK_THR) ? LOCK_THR : UNLOCK_THR,
  localparam int unsigned CNT_W     = $clog2(MAX_THR + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic match_i,
  output logic oos_o,
  output logic err_o
);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_THR - 1);
  localparam logic [CNT_W-1:0] UNLOCK_LAST = CNT_W'(UNLOCK_THR - 1);

  logic             oos_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic             toward_flip;
  logic [CNT_W-1:0] last;

  assign toward_flip = oos_q ? match_i : ~match_i;
  assign last        = oos_q ? LOCK_LAST : UNLOCK_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oos_q <= 1'b1;
      err_q <= 1'b0;
      cnt_q <= '0;
    end else if (vld_i) begin
      err_q <= ~oos_q & ~match_i;
      if (!toward_flip) begin
        cnt_q <= '0;
      end else if (cnt_q == last) begin
        cnt_q <= '0;
        oos_q <= ~oos_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      err_q <= 1'b0;
    end
  end

  assign oos_o = oos_q;
  assign err_o = err_q;
endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon #(
  parameter int unsigned LANES      = 4,
  parameter int unsigned LANE_W     = 14,
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned LOCK_THR   = 16,
  parameter int unsigned UNLOCK_THR = 64,
  localparam int unsigned W         = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SEL_W-1:0] seq_sel_i,
  input  logic [W-1:0]     data_i,
  output logic             oos_o,
  output logic             err_o
);
  logic [W-1:0] fmt_word;
  logic [W-1:0] in_q;
  logic         a_vld_q;
  logic [W-1:0] exp_word;
  logic         cmp_vld, cmp_match;

  prbs_lane_fmt #(.LANES(LANES), .LANE_W(LANE_W)) u_fmt (
    .raw_i  (data_i),
    .word_o (fmt_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= '0;
      a_vld_q <= 1'b0;
    end else begin
      a_vld_q <= valid_i;
      if (valid_i) in_q <= fmt_word;
    end
  end

  prbs_predictor #(.W(W), .SEL_W(SEL_W)) u_pred (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (a_vld_q),
    .reseed_i (oos_o),
    .sel_i    (seq_sel_i),
    .rx_i     (in_q),
    .exp_o    (exp_word)
  );

  prbs_compare #(.W(W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (a_vld_q),
    .rx_i    (in_q),
    .exp_i   (exp_word),
    .vld_o   (cmp_vld),
    .match_o (cmp_match)
  );

  prbs_lock #(.LOCK_THR(LOCK_THR), .UNLOCK_THR(UNLOCK_THR)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (cmp_vld),
    .match_i (cmp_match),
    .oos_o   (oos_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/prbs_sync_mon_sva.sv
module prbs_sync_mon_sva #(
  parameter int unsigned W = 56
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         oos_o,
  input logic         err_o,
  input logic         a_vld,
  input logic [W-1:0] in_q,
  input logic         cmp_vld,
  input logic         cmp_match
);
  a_r5_lock_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oos_o) |-> $past(cmp_vld && cmp_match));

  a_r7_unlock_needs_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oos_o) |-> $past(cmp_vld && !cmp_match));

  a_r8_err_only_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(!oos_o && cmp_vld && !cmp_match));

  a_r9_zero_never_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld && in_q == '0) |=> !cmp_match);

  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_vld |=> ($stable(oos_o) && !err_o));
endmodule

bind prbs_sync_mon prbs_sync_mon_sva #(.W(W)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oos_o     (oos_o),
  .err_o     (err_o),
  .a_vld     (a_vld_q),
  .in_q      (in_q),
  .cmp_vld   (cmp_vld),
  .cmp_match (cmp_match)
);

// File: tb/prbs_sync_mon_test.sv
module prbs_sync_mon_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  seq_sel_i = '0;
  logic [55:0] data_i = '0;
  logic        oos_o, err_o;

  int checks = 0, failures = 0, err_seen = 0, widx = 0;
  bit sbits [0:16383];

  prbs_sync_mon uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .seq_sel_i(seq_sel_i),
    .data_i(data_i), .oos_o(oos_o), .err_o(err_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) if (rst_ni && err_o) err_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: b[n] = b[n-len] ^ b[n-tap]
  task automatic fill(int len, int tap);
    for (int j = 0; j < 16384; j++)
      sbits[j] = (j < len) ? bit'((j % 3) != 1) : (sbits[j-len] ^ sbits[j-tap]);
    widx = 0;
  endtask

  function automatic logic [55:0] seq_word(int n);
    logic [55:0] w;
    for (int b = 0; b < 56; b++) w[55-b] = sbits[56*n + b];
    return w;
  endfunction

  // R2: inverse of lane packing / sign conversion
  function automatic logic [55:0] to_raw(logic [55:0] w);
    logic [55:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [13:0] lane;
      lane = w[(3-k)*14 +: 14];
      r[k*14 +: 14] = {~lane[13], lane[12:0]};
    end
    return r;
  endfunction

  function automatic logic [55:0] rnd56();
    return {$urandom, $urandom};
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      data_i  = rnd56();
    end
  endtask

  task automatic push(logic [55:0] raw, int gap);
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = raw;
    if (gap > 0) idle(gap);
  endtask

  task automatic push_seq(int gap);
    push(to_raw(seq_word(widx)), gap);
    widx++;
  endtask

  task automatic push_bad(int gap);
    push(to_raw(seq_word(widx) ^ (rnd56() | 56'd1)), gap);
    widx++;
  endtask

  initial begin
    int base;
    void'($urandom(32'd1234));
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    logic [55:0] w;
    repeat (3) @(negedge clk_i);
    chk("R1 oos after reset", oos_o, 1);
    chk("R1 err after reset", err_o, 0);
    rst_ni = 1'b1;

    // short pattern, select 0
    fill(9, 5);
    seq_sel_i = 4'd0;
    for (int i = 0; i < 16; i++) push_seq(0);
    idle(5);
    chk("R5 still oos after 15 matches", oos_o, 1);
    push_seq(0);
    idle(5);
    chk("R5 R2 R3 R4 locked after 16 matches", oos_o, 0);
    chk("R8 no err while out of sync", err_seen, 0);

    // R10: random gaps with garbage on data while locked
    for (int i = 0; i < 40; i++) push_seq($urandom_range(0, 2));
    idle(50);
    for (int i = 0; i < 5; i++) push_seq(0);
    idle(5);
    chk("R10 gaps ignored, err count", err_seen, 0);
    chk("R10 gaps ignored, oos", oos_o, 0);

    // R11 exact latency of one corrupted word
    w = seq_word(widx) ^ (56'd1 << $urandom_range(0, 55));
    widx++;
    @(negedge clk_i); valid_i = 1'b1; data_i = to_raw(w);
    @(negedge clk_i); valid_i = 1'b0;
    @(negedge clk_i); chk("R11 err not before edge k+2", err_o, 0);
    @(negedge clk_i); chk("R11 err after edge k+2", err_o, 1);
    @(negedge clk_i); chk("R8 err lasts one cycle", err_o, 0);
    for (int i = 0; i < 5; i++) push_seq($urandom_range(0, 1));
    idle(5);
    chk("R6 single flip gives one error", err_seen, 1);
    chk("R6 stays locked", oos_o, 0);

    // R9: zero word while locked
    push(to_raw(56'd0), 0);
    widx++;
    push_seq(0);
    idle(5);
    chk("R9 zero word is an error when locked", err_seen, 2);

    // R7: 63 bad, 1 good, 63 bad keeps lock
    for (int i = 0; i < 63; i++) push_bad(0);
    push_seq(0);
    for (int i = 0; i < 63; i++) push_bad($urandom_range(0, 1));
    idle(5);
    chk("R7 good word restarts unlock count", oos_o, 0);
    chk("R8 errors counted per bad word", err_seen, 128);
    push_bad(0);
    idle(5);
    chk("R7 unlock after 64 misses", oos_o, 1);
    chk("R8 last miss still flagged", err_seen, 129);

    // R8: garbage while out of sync
    for (int i = 0; i < 20; i++) push(rnd56(), $urandom_range(0, 1));
    idle(5);
    chk("R8 no err while out of sync", err_seen, 129);

    // R9: zeros never lock
    for (int i = 0; i < 40; i++) push(to_raw(56'd0), 0);
    idle(5);
    chk("R9 zero stream stays out of sync", oos_o, 1);

    // long pattern with nonzero select
    fill(23, 18);
    seq_sel_i = 4'd5;
    for (int i = 0; i < 16; i++) push_seq($urandom_range(0, 1));
    idle(5);
    chk("R5 long pattern not locked at 15", oos_o, 1);
    push_seq(0);
    idle(5);
    chk("R3 R4 long pattern locks", oos_o, 0);
    base = err_seen;

    // reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    idle(3);
    chk("R1 oos in reset", oos_o, 1);
    chk("R1 err in reset", err_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3: short pattern under nonzero select never locks
    fill(9, 5);
    seq_sel_i = 4'd3;
    for (int i = 0; i < 30; i++) push_seq(0);
    idle(5);
    chk("R3 wrong select stays out of sync", oos_o, 1);
    chk("R8 no err after reset while out of sync", err_seen, base);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule